// File: doc/BRIEF.md
# Conditional Branch Resolve and Predict Unit

This unit decides, in one registered stage, whether a conditional branch is taken and where it goes. It takes a 5-bit options field, one condition bit with a ready flag, the current counter and link values, and a branch kind of relative, to-link or to-counter. It returns the resolved decision, the counter write-back and the aligned branch target. When the condition bit is still pending, it returns the static hint from the options field as a predicted path for the prefetcher.

A prediction is made only while the condition is unresolved and the target is known. A branch to link or to counter whose target register is not yet ready produces no prediction. Encodings that set reserved "don't care" bits behave exactly like the encoding with those bits cleared.

Top module: `cond_branch_unit`

## Requirements
- R1: Options bits (MSB first) are: bit4 skip condition test, bit3 required condition value, bit2 skip counter decrement, bit1 branch when decremented counter is zero (0 = when non-zero), bit0 hint. When the condition is resolved (condReady high or bit4 set), `taken` is 1 exactly when the counter test passes and the condition test passes. The counter test passes when bit2 is set or when (ctrIn-1 == 0) equals bit1. The condition test passes when bit4 is set or when condBit equals bit3.
- R2: Bit3 has no effect on any output when bit4 is set. Bit1 has no effect on any output when bit2 is set.
- R3: When bit2 is clear, `ctrWrEn` is 1 and `ctrWrData` equals ctrIn-1 (modulo 2^32), whatever the branch outcome. When bit2 is set, `ctrWrEn` is 0.
- R4: For kind 2 (to counter), `target` is ctrIn-1 when bit2 is clear and ctrIn when bit2 is set, with bits [1:0] forced to 0.
- R5: For kind 1 (to link), `target` is linkIn with bits [1:0] forced to 0. For kind 0 (relative) and the reserved kind 3, `target` is relTarget unchanged.
- R6: When the condition is unresolved (condReady low and bit4 clear) and the target is ready, `predValid` is 1, `predTaken` equals bit0, and `taken` is 0. The target is ready for a relative branch, tracks `linkReady` for kind 1, and tracks `ctrReady` for kind 2.
- R7: When the condition is resolved, `predValid` and `predTaken` are 0.
- R8: A kind 1 or kind 2 branch whose target is not ready produces `predValid` = 0 and `predTaken` = 0.
- R9: All outputs update one clock after an `inValid` cycle, and `outValid` marks that cycle. In other cycles `outValid`, `taken`, `predValid`, `predTaken` and `ctrWrEn` are 0. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Branch presented this cycle |
| opts | input | 5 | Branch options field |
| condBit | input | 1 | Selected condition bit |
| condReady | input | 1 | Condition bit is valid |
| ctrIn | input | 32 | Counter register value |
| ctrReady | input | 1 | Counter value is valid as a target |
| linkIn | input | 32 | Link register value |
| linkReady | input | 1 | Link value is valid as a target |
| kind | input | 2 | 0 relative, 1 to link, 2 to counter, 3 treated as relative |
| relTarget | input | 32 | Precomputed relative target |
| outValid | output | 1 | Result valid |
| taken | output | 1 | Resolved taken decision |
| predValid | output | 1 | Prediction issued |
| predTaken | output | 1 | Predicted path (1 = taken) |
| target | output | 32 | Branch target |
| ctrWrEn | output | 1 | Counter write-back strobe |
| ctrWrData | output | 32 | Decremented counter value |

## Verification
The unit holds no state across branches. A wrong internal value therefore shows up on the ports in the single cycle after the `inValid` that caused it: a wrong decrement or zero detect shows in `ctrWrData`, `taken` or the counter target, and a wrong resolved/unresolved split shows as `predValid` and `taken` disagreeing with the ready flags. Sweeping all 32 option encodings with counters of 0, 1 and 2 reaches both zero-detect polarities and the wrap from 0 to all ones. Reserved-bit pairs are compared directly to show that those bits have no effect.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  localparam int OPT_NOCOND  = 4;
  localparam int OPT_CONDVAL = 3;
  localparam int OPT_NODEC   = 2;
  localparam int OPT_ONZERO  = 1;
  localparam int OPT_HINT    = 0;
  localparam int OPT_W       = 5;

  typedef enum logic [1:0] {
    KIND_REL  = 2'd0,
    KIND_LINK = 2'd1,
    KIND_CTR  = 2'd2,
    KIND_RSVD = 2'd3
  } brKind_t;

  typedef struct packed {
    logic load;          // capture target this cycle
    logic decEn;         // write back decremented counter
    logic useDecTarget;  // counter target uses decremented value
  } dpStrobe_t;
endpackage

// File: rtl/cbu_control.sv
module cbu_control
  import cbu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPT_W-1:0] opts,
  input  logic             condBit,
  input  logic             condReady,
  input  logic             linkReady,
  input  logic             ctrReady,
  input  brKind_t          kind,
  input  logic             ctrDecZero,
  output dpStrobe_t        strobe,
  output logic             outValid,
  output logic             taken,
  output logic             predValid,
  output logic             predTaken
);
  logic condResolved, condPass, ctrPass, targetReady, predictNow, resolvedTaken;

  always_comb begin
    condResolved  = opts[OPT_NOCOND] | condReady;
    condPass      = opts[OPT_NOCOND] | (condBit == opts[OPT_CONDVAL]);
    ctrPass       = opts[OPT_NODEC] | (ctrDecZero == opts[OPT_ONZERO]);
    resolvedTaken = condResolved & condPass & ctrPass;
    unique case (kind)
      KIND_LINK: targetReady = linkReady;
      KIND_CTR:  targetReady = ctrReady;
      default:   targetReady = 1'b1;
    endcase
    predictNow = ~condResolved & targetReady;

    strobe.load         = inValid;
    strobe.decEn        = inValid & ~opts[OPT_NODEC];
    strobe.useDecTarget = ~opts[OPT_NODEC];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      taken     <= 1'b0;
      predValid <= 1'b0;
      predTaken <= 1'b0;
    end else begin
      outValid  <= inValid;
      taken     <= inValid & resolvedTaken;
      predValid <= inValid & predictNow;
      predTaken <= inValid & predictNow & opts[OPT_HINT];
    end
  end
endmodule

// File: rtl/cbu_datapath.sv
module cbu_datapath
  import cbu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  brKind_t          kind,
  input  logic [WIDTH-1:0] ctrIn,
  input  logic [WIDTH-1:0] linkIn,
  input  logic [WIDTH-1:0] relTarget,
  output logic             ctrDecZero,
  output logic [WIDTH-1:0] target,
  output logic             ctrWrEn,
  output logic [WIDTH-1:0] ctrWrData
);
  localparam logic [WIDTH-1:0] ALIGN_MASK = {{(WIDTH-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};
  localparam logic [WIDTH-1:0] ONE        = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] ctrDec, ctrSel, nextTarget;

  always_comb begin
    ctrDec     = ctrIn - ONE;
    ctrDecZero = (ctrDec == '0);
    ctrSel     = strobe.useDecTarget ? ctrDec : ctrIn;
    unique case (kind)
      KIND_LINK: nextTarget = linkIn & ALIGN_MASK;
      KIND_CTR:  nextTarget = ctrSel & ALIGN_MASK;
      default:   nextTarget = relTarget;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      target    <= '0;
      ctrWrEn   <= 1'b0;
      ctrWrData <= '0;
    end else begin
      ctrWrEn <= strobe.decEn;
      if (strobe.load)  target    <= nextTarget;
      if (strobe.decEn) ctrWrData <= ctrDec;
    end
  end
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit
  import cbu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [4:0]       opts,
  input  logic             condBit,
  input  logic             condReady,
  input  logic [WIDTH-1:0] ctrIn,
  input  logic             ctrReady,
  input  logic [WIDTH-1:0] linkIn,
  input  logic             linkReady,
  input  logic [1:0]       kind,
  input  logic [WIDTH-1:0] relTarget,
  output logic             outValid,
  output logic             taken,
  output logic             predValid,
  output logic             predTaken,
  output logic [WIDTH-1:0] target,
  output logic             ctrWrEn,
  output logic [WIDTH-1:0] ctrWrData
);
  dpStrobe_t strobe;
  logic      ctrDecZero;
  brKind_t   kindE;

  assign kindE = brKind_t'(kind);

  cbu_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opts(opts),
    .condBit(condBit), .condReady(condReady), .linkReady(linkReady),
    .ctrReady(ctrReady), .kind(kindE), .ctrDecZero(ctrDecZero),
    .strobe(strobe), .outValid(outValid), .taken(taken),
    .predValid(predValid), .predTaken(predTaken)
  );

  cbu_datapath #(.WIDTH(WIDTH), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .kind(kindE),
    .ctrIn(ctrIn), .linkIn(linkIn), .relTarget(relTarget),
    .ctrDecZero(ctrDecZero), .target(target),
    .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData)
  );
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [4:0]       opts,
  input logic             condReady,
  input logic [WIDTH-1:0] ctrIn,
  input logic [WIDTH-1:0] linkIn,
  input logic [1:0]       kind,
  input logic             outValid,
  input logic             taken,
  input logic             predValid,
  input logic             predTaken,
  input logic [WIDTH-1:0] target,
  input logic             ctrWrEn,
  input logic [WIDTH-1:0] ctrWrData
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(taken || predValid || ctrWrEn)); // R9
  AST_PRED_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> (outValid && !taken)); // R6
  AST_RESOLVED_NO_PRED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (condReady || opts[4])) |=> !predValid); // R7
  AST_HINT_PASSED: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !condReady && !opts[4] && kind == 2'd0) |=> (predValid && predTaken == $past(opts[0]))); // R6
  AST_NO_WB_ON_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opts[2]) |=> !ctrWrEn); // R3
  AST_WB_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opts[2]) |=> (ctrWrEn && ctrWrData == $past(ctrIn) - 1)); // R3
  AST_LINK_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && kind == 2'd1) |=> (target == {$past(linkIn[WIDTH-1:2]), 2'b00})); // R5
endmodule

bind cond_branch_unit cbu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opts(opts), .condReady(condReady),
  .ctrIn(ctrIn), .linkIn(linkIn), .kind(kind), .outValid(outValid), .taken(taken),
  .predValid(predValid), .predTaken(predTaken), .target(target),
  .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData)
);

// File: tb/cond_branch_unit_test.sv
`timescale 1ns/1ps
module cond_branch_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [4:0]  opts = '0;
  logic        condBit = 1'b0, condReady = 1'b0, ctrReady = 1'b0, linkReady = 1'b0;
  logic [31:0] ctrIn = '0, linkIn = '0, relTarget = '0;
  logic [1:0]  kind = '0;
  logic        outValid, taken, predValid, predTaken, ctrWrEn;
  logic [31:0] target, ctrWrData;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;
  logic lastTaken, lastPredV, lastPredT;
  logic [31:0] lastTarget;

  always #2 clk = ~clk;

  cond_branch_unit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opts(opts), .condBit(condBit),
    .condReady(condReady), .ctrIn(ctrIn), .ctrReady(ctrReady), .linkIn(linkIn),
    .linkReady(linkReady), .kind(kind), .relTarget(relTarget),
    .outValid(outValid), .taken(taken), .predValid(predValid), .predTaken(predTaken),
    .target(target), .ctrWrEn(ctrWrEn), .ctrWrData(ctrWrData)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expTarget(input logic [4:0] o, input logic [1:0] k,
      input logic [31:0] c, input logic [31:0] l, input logic [31:0] r);
    if (k == 2'd1) return {l[31:2], 2'b00};
    if (k == 2'd2) return o[2] ? {c[31:2], 2'b00} : {(c - 32'd1) >> 2, 2'b00};
    return r;
  endfunction

  task automatic runOne(input logic [4:0] o, input logic cb, input logic cr,
      input logic [31:0] c, input logic cRdy, input logic [31:0] l, input logic lRdy,
      input logic [1:0] k, input logic [31:0] r);
    logic resolved, tgtRdy, cPass, kPass, eTaken, ePredV, ePredT;
    @(negedge clk);
    opts = o; condBit = cb; condReady = cr; ctrIn = c; ctrReady = cRdy;
    linkIn = l; linkReady = lRdy; kind = k; relTarget = r; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    resolved = cr | o[4];
    cPass    = o[4] | (cb == o[3]);
    kPass    = o[2] | (((c - 32'd1) == 32'd0) == o[1]);
    tgtRdy   = (k == 2'd1) ? lRdy : (k == 2'd2) ? cRdy : 1'b1;
    eTaken   = resolved & cPass & kPass;
    ePredV   = ~resolved & tgtRdy;
    ePredT   = ePredV & o[0];
    chk("R9", "outValid", {31'd0, outValid}, 32'd1);
    if (resolved) chk("R1", "taken", {31'd0, taken}, {31'd0, eTaken});
    else          chk("R6", "taken while unresolved", {31'd0, taken}, 32'd0);
    if (resolved)             chk("R7", "predValid", {31'd0, predValid}, 32'd0);
    else if (!tgtRdy)         chk("R8", "predValid", {31'd0, predValid}, 32'd0);
    else                      chk("R6", "predValid", {31'd0, predValid}, 32'd1);
    chk(ePredV ? "R6" : "R7", "predTaken", {31'd0, predTaken}, {31'd0, ePredT});
    chk(k == 2'd2 ? "R4" : "R5", "target", target, expTarget(o, k, c, l, r));
    chk("R3", "ctrWrEn", {31'd0, ctrWrEn}, {31'd0, ~o[2]});
    if (!o[2]) chk("R3", "ctrWrData", ctrWrData, c - 32'd1);
    lastTaken = taken; lastPredV = predValid; lastPredT = predTaken; lastTarget = target;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic tA, pA, qA;
    logic [31:0] gA;
    int seedDummy;
    seedDummy = $urandom(32'h1BAD5EED);
    repeat (3) @(negedge clk);
    chk("R9", "reset outValid", {31'd0, outValid}, 32'd0);
    chk("R9", "reset target", target, 32'd0);
    chk("R9", "reset ctrWrData", ctrWrData, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep every encoding against counters 0, 1, 2 and all kinds.
    for (int o = 0; o < 32; o++)
      for (int c = 0; c < 3; c++)
        for (int k = 0; k < 4; k++) begin
          runOne(o[4:0], o[0] ^ c[0], c[0], c, 1'b1, 32'hCAFE_F00F, 1'b1, k[1:0], 32'h0000_1234);
          runOne(o[4:0], c[1], 1'b0, c, k[0], 32'h8765_4323, k[1], k[1:0], 32'h0000_4440);
        end

    // Idle cycle after a branch: everything quiet.
    @(negedge clk);
    chk("R9", "idle outValid", {31'd0, outValid}, 32'd0);
    chk("R9", "idle ctrWrEn", {31'd0, ctrWrEn}, 32'd0);

    // Reserved bits ignored: bit3 under bit4, bit1 under bit2.
    for (int v = 0; v < 8; v++) begin
      runOne({1'b1, 1'b0, v[0], 1'b0, v[1]}, v[2], 1'b1, 32'd1, 1'b1, 32'h10, 1'b1, 2'd2, 32'h20);
      tA = lastTaken; pA = lastPredV; qA = lastPredT; gA = lastTarget;
      runOne({1'b1, 1'b1, v[0], 1'b0, v[1]}, v[2], 1'b1, 32'd1, 1'b1, 32'h10, 1'b1, 2'd2, 32'h20);
      chk("R2", "bit3 ignored taken", {31'd0, lastTaken}, {31'd0, tA});
      chk("R2", "bit3 ignored pred", {30'd0, lastPredV, lastPredT}, {30'd0, pA, qA});
      runOne({v[0], v[1], 1'b1, 1'b0, 1'b0}, v[2], 1'b0, 32'd1, 1'b1, 32'h10, 1'b1, 2'd2, 32'h20);
      tA = lastTaken; pA = lastPredV; gA = lastTarget;
      runOne({v[0], v[1], 1'b1, 1'b1, 1'b0}, v[2], 1'b0, 32'd1, 1'b1, 32'h10, 1'b1, 2'd2, 32'h20);
      chk("R2", "bit1 ignored taken", {31'd0, lastTaken}, {31'd0, tA});
      chk("R2", "bit1 ignored target", lastTarget, gA);
    end

    // Counter wrap and count target post-decrement (R4).
    runOne(5'b10000, 1'b0, 1'b1, 32'd0, 1'b1, 32'd0, 1'b1, 2'd2, 32'd0);
    chk("R4", "wrap target", lastTarget, 32'hFFFF_FFFC);
    runOne(5'b10100, 1'b0, 1'b1, 32'h0000_0107, 1'b1, 32'd0, 1'b1, 2'd2, 32'd0);
    chk("R4", "no-dec target", lastTarget, 32'h0000_0104);

    // Random mix.
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rc;
      rc = ($urandom % 4 == 0) ? ($urandom % 3) : $urandom;
      runOne($urandom, $urandom, $urandom, rc, $urandom, $urandom, $urandom, $urandom, $urandom);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule